// File: doc/BRIEF.md
# CVSD Codec Digital Core

This block is the shared digital loop of a half-duplex continuously variable slope delta codec. It runs one bit per enabled cycle, so the rate of `bit_en` strobes is the bit rate. The signal estimate is a signed word that stands in for the rebuilt audio level. In encode mode the core compares a signed sample word against this estimate and emits one bit. In decode mode it takes the received bit instead. In both modes the same bit drives the same loop, so a decoder fed the encoder's bits tracks the encoder's estimate.

The step size is adaptive. The core keeps a short history of recent bits. When the newest bits all agree, which indicates slope overload, it adds a fixed boost to a leaky step-size integrator. The estimate itself is a second leaky integrator. It moves up or down by the current step and then leaks a fraction of itself toward zero. Both leaks are shifts, so both time constants are fixed numbers of bit periods.

Near the rails the estimate is clamped at three-quarters of full scale, and any further outward movement is refused. A gain-control flag goes low while the estimate magnitude is at or above half of full scale. A synchronous clear input returns the loop to its idle state.

Top module: `cvsd_core`

## Requirements
- R1: In encode mode (`dec_mode`=0), an enabled cycle sets `tx_bit` to 1 when the signed `sample_in` is greater than or equal to the current signed estimate, and to 0 otherwise. The new value is visible after that clock edge.
- R2: In decode mode (`dec_mode`=1), an enabled cycle uses `rx_bit` as the loop bit, and `tx_bit` repeats it after the edge.
- R3: A 3-bit history register shifts the loop bit in on every enabled cycle, and its idle value is binary 010. A cycle whose new history is 000 or 111 is a coincidence, and it adds 8 to the step size. A cycle without coincidence adds nothing.
- R4: Each enabled, non-frozen cycle, the step size becomes step − (step >> 6) + boost. The result is limited to the range 1 to 128, and the idle step is 1.
- R5: Each enabled, non-frozen cycle, the estimate first adds the step size (bit 1) or subtracts it (bit 0), using the step from before this cycle's update. It then subtracts that intermediate value arithmetically shifted right by 4.
- R6: The estimate is limited to ±384 (three-quarters of the ±512 range), and `clamped` is 1 exactly when the estimate magnitude is 384 or more. A clamped estimate with a loop bit pointing outward (1 when the estimate is positive, 0 when it is not) freezes both the estimate and the step for that cycle. A bit pointing inward proceeds normally.
- R7: `agc_n` is 0 while the estimate magnitude is 256 or more, and 1 otherwise.
- R8: `level_out` is the estimate in offset binary, equal to estimate + 512, so 512 means zero signal.
- R9: `flt_clear`=1 at a clock edge sets the estimate to 0, the step to 1, the history to 010 and `tx_bit` to 0, whatever `bit_en` is.
- R10: A cycle with `bit_en`=0 and `flt_clear`=0 changes none of `tx_bit`, `level_out`, `clamped`, `agc_n`, the step size or the history.
- R11: While `rst_n` is low, the core is held in the same idle state that R9 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| dec_mode | input | 1 | 0 encodes, 1 decodes |
| flt_clear | input | 1 | Synchronous return of the loop to idle |
| sample_in | input | 10 | Signed sample word (encode mode) |
| rx_bit | input | 1 | Received bit (decode mode) |
| tx_bit | output | 1 | Loop bit of the last enabled cycle |
| level_out | output | 10 | Reconstructed level, offset binary |
| clamped | output | 1 | Estimate at the three-quarter-scale limit |
| agc_n | output | 1 | Low while the estimate magnitude is at least half scale |

## Verification
The embedded properties assume that `bit_en`, `dec_mode`, `flt_clear`, `sample_in` and `rx_bit` are settled before each rising edge and are known values whenever `rst_n` is high. They also assume the default step limits, which keep the widened intermediate sum from overflowing. The stimulus changes inputs only just after falling edges and holds them through the following rising edge. It keeps every sample inside the signed 10-bit range and mixes enabled, idle and clearing cycles. These include sweeps that drive the estimate into both clamp rails and back out again.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

   // alternating bit pattern used as the quiet history value
   function automatic logic [31:0] idle_pattern(input int n);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < n; i++) begin
         r[i] = (i % 2) == 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/cvsd_run_detect.sv
module cvsd_run_detect #(
   parameter int RUN_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic adv_i,
   input  logic bit_i,
   output logic coin_o
);
   import cvsd_pkg::*;

   localparam logic [RUN_LEN-1:0] IDLE = RUN_LEN'(idle_pattern(RUN_LEN));

   logic [RUN_LEN-1:0] hist_q;
   logic [RUN_LEN-1:0] hist_nxt;
   logic [RUN_LEN-1:0] same;

   assign hist_nxt = {hist_q[RUN_LEN-2:0], bit_i};

   for (genvar i = 0; i < RUN_LEN; i++) begin : g_eq
      assign same[i] = (hist_nxt[i] == hist_nxt[0]);
   end

   assign coin_o = &same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= IDLE;
      end else if (clear_i) begin
         hist_q <= IDLE;
      end else if (adv_i) begin
         hist_q <= hist_nxt;
      end
   end

   // R9: clear restores the quiet history
   a_r9_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> hist_q == IDLE);

   // R10: no strobe, no history movement
   a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !clear_i) |=> $stable(hist_q));

endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
   parameter int W          = 10,
   parameter int STEP_SHIFT = 6,
   parameter int STEP_INC   = 8,
   parameter int STEP_MIN   = 1,
   parameter int STEP_MAX   = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         adv_i,
   input  logic         coin_i,
   output logic [W-1:0] step_o
);

   localparam logic [W:0]   INC_X = (W+1)'(STEP_INC);
   localparam logic [W:0]   MIN_X = (W+1)'(STEP_MIN);
   localparam logic [W:0]   MAX_X = (W+1)'(STEP_MAX);
   localparam logic [W-1:0] MIN_W = W'(STEP_MIN);

   logic [W-1:0] step_q;
   logic [W:0]   step_x;
   logic [W:0]   sum;
   logic [W:0]   lim;

   assign step_x = {1'b0, step_q};
   assign sum    = step_x - (step_x >> STEP_SHIFT) + (coin_i ? INC_X : '0);

   always_comb begin
      if (sum > MAX_X) begin
         lim = MAX_X;
      end else if (sum < MIN_X) begin
         lim = MIN_X;
      end else begin
         lim = sum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= MIN_W;
      end else if (clear_i) begin
         step_q <= MIN_W;
      end else if (adv_i) begin
         step_q <= lim[W-1:0];
      end
   end

   assign step_o = step_q;

   // R4: step stays inside its limits
   a_r4_step_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q >= MIN_W) && ({1'b0, step_q} <= MAX_X));

   // R3: a coincidence never shrinks the step
   a_r3_boost_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && coin_i && !clear_i) |=> step_q >= $past(step_q));

   // R4: without coincidence the step only decays
   a_r4_decay_only: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !coin_i && !clear_i) |=> step_q <= $past(step_q));

endmodule

// File: rtl/cvsd_estimate.sv
module cvsd_estimate #(
   parameter int W         = 10,
   parameter int EST_SHIFT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                en_i,
   input  logic                bit_i,
   input  logic [W-1:0]        step_i,
   output logic signed [W-1:0] est_o,
   output logic                inhibit_o,
   output logic                clamped_o,
   output logic                agc_n_o
);
   import cvsd_pkg::*;

   localparam int EW    = W + 2;
   localparam int MID   = 1 << (W - 1);
   localparam int CLAMP = (3 * MID) / 4;
   localparam int HALF  = MID / 2;

   localparam logic signed [EW-1:0] CL_P = EW'(CLAMP);
   localparam logic signed [EW-1:0] CL_N = -CL_P;
   localparam logic signed [W-1:0]  CW_P = W'(CLAMP);
   localparam logic signed [W-1:0]  CW_N = -CW_P;
   localparam logic signed [W-1:0]  HW_P = W'(HALF);
   localparam logic signed [W-1:0]  HW_N = -HW_P;

   logic signed [W-1:0]  est_q;
   logic signed [EW-1:0] e_ext;
   logic signed [EW-1:0] st_ext;
   logic signed [EW-1:0] e1;
   logic signed [EW-1:0] leak;
   logic signed [EW-1:0] e2;
   logic signed [EW-1:0] e_lim;
   dir_e                 dir;

   assign dir    = dir_e'(bit_i);
   assign e_ext  = {{(EW-W){est_q[W-1]}}, est_q};
   assign st_ext = {{(EW-W){1'b0}}, step_i};
   assign e1     = (dir == DIR_UP) ? (e_ext + st_ext) : (e_ext - st_ext);

   if (EST_SHIFT == 0) begin : g_no_leak
      assign leak = '0;
   end else begin : g_leak
      assign leak = e1 >>> EST_SHIFT;
   end

   assign e2 = e1 - leak;

   always_comb begin
      if (e2 > CL_P) begin
         e_lim = CL_P;
      end else if (e2 < CL_N) begin
         e_lim = CL_N;
      end else begin
         e_lim = e2;
      end
   end

   assign clamped_o = (est_q >= CW_P) || (est_q <= CW_N);
   assign agc_n_o   = !((est_q >= HW_P) || (est_q <= HW_N));
   assign inhibit_o = clamped_o && ((dir == DIR_UP) == (est_q > 0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         est_q <= '0;
      end else if (clear_i) begin
         est_q <= '0;
      end else if (en_i && !inhibit_o) begin
         est_q <= e_lim[W-1:0];
      end
   end

   assign est_o = est_q;

   // R6: estimate never passes the clamp rails
   a_r6_in_rails: assert property (@(posedge clk) disable iff (!rst_n)
      (est_q <= CW_P) && (est_q >= CW_N));

   // R6: outward bit while clamped freezes the estimate
   a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && inhibit_o && !clear_i) |=> $stable(est_q));

   // R9: clear returns the estimate to zero
   a_r9_est_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> est_q == '0);

endmodule

// File: rtl/cvsd_core.sv
module cvsd_core #(
   parameter int W          = 10,
   parameter int RUN_LEN    = 3,
   parameter int STEP_SHIFT = 6,
   parameter int EST_SHIFT  = 4,
   parameter int STEP_INC   = 8,
   parameter int STEP_MIN   = 1,
   parameter int STEP_MAX   = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_en,
   input  logic                dec_mode,
   input  logic                flt_clear,
   input  logic signed [W-1:0] sample_in,
   input  logic                rx_bit,
   output logic                tx_bit,
   output logic [W-1:0]        level_out,
   output logic                clamped,
   output logic                agc_n
);

   localparam int MID = 1 << (W - 1);

   if (W < 4) begin : g_bad_w
      $error("cvsd_core: W must be at least 4");
   end
   if (RUN_LEN < 2 || RUN_LEN > 32) begin : g_bad_run
      $error("cvsd_core: RUN_LEN must be 2..32");
   end
   if (STEP_MIN < 1 || STEP_MAX < STEP_MIN || STEP_MAX > MID) begin : g_bad_step
      $error("cvsd_core: step limits out of range");
   end
   if (STEP_INC < 0 || STEP_INC >= MID) begin : g_bad_inc
      $error("cvsd_core: STEP_INC out of range");
   end
   if (STEP_SHIFT < 1 || EST_SHIFT < 0 || EST_SHIFT >= W) begin : g_bad_shift
      $error("cvsd_core: shift amounts out of range");
   end

   logic                loop_bit;
   logic                coin;
   logic                inhibit;
   logic [W-1:0]        step;
   logic signed [W-1:0] est;
   logic                tx_q;

   assign loop_bit = dec_mode ? rx_bit : (sample_in >= est);

   cvsd_run_detect #(
      .RUN_LEN (RUN_LEN)
   ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (flt_clear),
      .adv_i   (bit_en),
      .bit_i   (loop_bit),
      .coin_o  (coin)
   );

   cvsd_syllabic #(
      .W          (W),
      .STEP_SHIFT (STEP_SHIFT),
      .STEP_INC   (STEP_INC),
      .STEP_MIN   (STEP_MIN),
      .STEP_MAX   (STEP_MAX)
   ) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (flt_clear),
      .adv_i   (bit_en && !inhibit),
      .coin_i  (coin),
      .step_o  (step)
   );

   cvsd_estimate #(
      .W         (W),
      .EST_SHIFT (EST_SHIFT)
   ) u_est (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (flt_clear),
      .en_i      (bit_en),
      .bit_i     (loop_bit),
      .step_i    (step),
      .est_o     (est),
      .inhibit_o (inhibit),
      .clamped_o (clamped),
      .agc_n_o   (agc_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= 1'b0;
      end else if (flt_clear) begin
         tx_q <= 1'b0;
      end else if (bit_en) begin
         tx_q <= loop_bit;
      end
   end

   assign tx_bit    = tx_q;
   assign level_out = {~est[W-1], est[W-2:0]};

   // R1: encoder bit follows the comparison made at the strobe
   a_r1_enc_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !dec_mode && !flt_clear) |=>
         tx_bit == ($signed($past(sample_in)) >= $signed($past(est))));

   // R2: decoder bit follows the received stream
   a_r2_dec_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && dec_mode && !flt_clear) |=> tx_bit == $past(rx_bit));

   // R10: idle cycles leave outputs alone
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !flt_clear) |=> ($stable(level_out) && $stable(tx_bit)));

   // R9: clear drops the output bit
   a_r9_tx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flt_clear |=> !tx_bit);

endmodule

// File: tb/tb_cvsd_core.sv
`timescale 1ns/1ps
module tb_cvsd_core;

   localparam int W = 10;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                bit_en = 1'b0;
   logic                dec_mode = 1'b0;
   logic                flt_clear = 1'b0;
   logic signed [W-1:0] sample_in = '0;
   logic                rx_bit = 1'b0;
   logic                tx_bit;
   logic [W-1:0]        level_out;
   logic                clamped;
   logic                agc_n;

   cvsd_core dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .dec_mode  (dec_mode),
      .flt_clear (flt_clear),
      .sample_in (sample_in),
      .rx_bit    (rx_bit),
      .tx_bit    (tx_bit),
      .level_out (level_out),
      .clamped   (clamped),
      .agc_n     (agc_n)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int       m_est;
   int       m_step;
   logic [2:0] m_hist;
   int       m_tx;
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic model_idle();
      m_est  = 0;
      m_step = 1;
      m_hist = 3'b010;
      m_tx   = 0;
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " R1 R2 tx_bit"}, int'(tx_bit), m_tx);
      chk({tag, " R4 R5 R8 level_out"}, int'(level_out), m_est + 512);
      chk({tag, " R6 clamped"}, int'(clamped), (iabs(m_est) >= 384) ? 1 : 0);
      chk({tag, " R7 agc_n"}, int'(agc_n), (iabs(m_est) >= 256) ? 0 : 1);
   endtask

   task automatic model_step(input bit en, input bit dec, input bit clr,
                             input int smp, input bit rx);
      int b, e1, e2, s1, pos;
      bit coin, inh;
      logic [2:0] nh;
      if (clr) begin
         model_idle();
      end else if (en) begin
         b    = dec ? int'(rx) : ((smp >= m_est) ? 1 : 0);
         nh   = {m_hist[1:0], b[0]};
         coin = (nh == 3'b000) || (nh == 3'b111);
         pos  = (m_est > 0) ? 1 : 0;
         inh  = (iabs(m_est) >= 384) && (b == pos);
         m_hist = nh;
         m_tx   = b;
         if (!inh) begin
            e1 = (b == 1) ? m_est + m_step : m_est - m_step;
            e2 = e1 - (e1 >>> 4);
            if (e2 > 384) e2 = 384;
            if (e2 < -384) e2 = -384;
            s1 = m_step - (m_step >> 6) + (coin ? 8 : 0);
            if (s1 > 128) s1 = 128;
            if (s1 < 1) s1 = 1;
            m_est  = e2;
            m_step = s1;
         end
      end
   endtask

   task automatic cyc(input bit en, input bit dec, input bit clr,
                      input int smp, input bit rx, input string tag);
      @(negedge clk);
      check_outs(tag);
      bit_en    = en;
      dec_mode  = dec;
      flt_clear = clr;
      sample_in = W'(smp);
      rx_bit    = rx;
      model_step(en, dec, clr, smp, rx);
   endtask

   function automatic logic [15:0] lfsr(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_idle();
      repeat (3) @(negedge clk);
      // R11: idle state held under reset
      check_outs("R11 reset");
      rst_n = 1'b1;

      // R1 R3 R4 R5: encode constant positive level
      for (int i = 0; i < 120; i++) cyc(1, 0, 0, 200, 0, "R1 R3 enc+200");
      // R1 R5: encode constant negative level
      for (int i = 0; i < 120; i++) cyc(1, 0, 0, -300, 0, "R1 R5 enc-300");

      // R6 R7: drive into positive rail, hold, then come back
      for (int i = 0; i < 80; i++) cyc(1, 0, 0, 511, 0, "R6 enc rail+");
      for (int i = 0; i < 80; i++) cyc(1, 0, 0, -512, 0, "R6 enc rail-");
      for (int i = 0; i < 60; i++) cyc(1, 0, 0, 0, 0, "R6 enc release");

      // R1 R4: triangle sweeps over the full range
      for (int k = 0; k < 4; k++) begin
         for (int v = -512; v < 512; v += 16) cyc(1, 0, 0, v, 0, "R1 tri up");
         for (int v = 511; v > -512; v -= 16) cyc(1, 0, 0, v, 0, "R1 tri down");
      end

      // R9: explicit clear check
      cyc(1, 0, 1, 300, 0, "R9 clear");
      cyc(0, 0, 0, 300, 0, "R9 after clear");

      // R1 R9: every sample value, clear every 128 samples
      for (int v = -512; v < 512; v++) begin
         cyc(1, 0, ((v & 127) == 0), v, 0, "R1 R9 sweep");
      end

      // R2 R6: decoder fed all ones then all zeros
      for (int i = 0; i < 150; i++) cyc(1, 1, 0, 0, 1, "R2 R6 dec ones");
      for (int i = 0; i < 150; i++) cyc(1, 1, 0, 0, 0, "R2 R6 dec zeros");
      // R3: alternating pattern never boosts
      for (int i = 0; i < 150; i++) cyc(1, 1, 0, 0, i[0], "R3 dec alt");
      // R3: runs of two and three
      for (int i = 0; i < 300; i++) cyc(1, 1, 0, 0, ((i % 5) < 3), "R3 dec runs");

      // R2: pseudo-random decode stream
      for (int i = 0; i < 3000; i++) begin
         lf = lfsr(lf);
         cyc(1, 1, 0, 0, lf[0], "R2 dec prbs");
      end

      // R10 R9: gated strobes with occasional clears
      for (int i = 0; i < 3000; i++) begin
         lf = lfsr(lf);
         cyc(lf[3], lf[5], (lf[15:11] == 5'd0), int'($signed(lf[9:0])), lf[0],
             "R10 R9 gated");
      end

      // R10: long idle with changing inputs
      for (int i = 0; i < 200; i++) begin
         lf = lfsr(lf);
         cyc(0, lf[1], 0, int'($signed(lf[12:3])), lf[0], "R10 idle");
      end

      @(negedge clk);
      check_outs("final");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule